// File: doc/BRIEF.md
# Pipeline Activity Tracker and Idle Detector

This block keeps a running count of the work still in flight in a multi-stage pipeline. A clock-gating or sleep controller can use it to stop ticking the pipeline once nothing remains. Two kinds of event feed the count. The first is a per-cycle pulse meaning "some inter-stage channel was written". It is recorded in a history line as long as the longest inter-stage latency. The second is a set of per-stage activate and deactivate requests, which set and clear one sticky flag per stage. The count is kept incrementally and always equals the set history slots plus the set stage flags, plus any preload. Idleness is therefore the single test "count is zero", with no wide OR across the history and the flags.

A history advance input moves every recorded pulse one slot older. A pulse that falls off the oldest slot is subtracted. All increments and decrements that land in one cycle are summed into a single update. A synchronous flush empties the history, the flags and the count.

A two-state machine tracks the idle period and accumulates idle time for wake events. The states are `ST_IDLE` (the count is zero) and `ST_RUN` (the count is non-zero). It has two transitions:
- `T_START` goes from `ST_IDLE` to `ST_RUN` when the next count is non-zero.
- `T_STOP` goes from `ST_RUN` to `ST_IDLE` when the next count is zero. It records the current cycle index as the last running cycle.

The cycle index is the number of rising edges completed since reset was released, so the first edge after release has index 0. A wake request arriving while the block is idle and no tick is pending adds (index − 1 − last running cycle) to the idle total. Any other wake request is ignored.

Top module: `pipe_idle_tracker`

## Requirements
- R1: After reset the count equals the parameter INIT_COUNT (default 0). `active_o` is high only if INIT_COUNT is non-zero. The history and the flags are empty, and `idle_total_o` is 0.
- R2: With `advance_i` high, a single `pulse_i` raises the count by one. The count stays raised for exactly LATENCY cycles after the edge that took the pulse.
- R3: While `advance_i` is low, repeated pulses all land in the newest slot and raise the count only once.
- R4: On an advance, a set entry leaving the oldest slot lowers the count by one in that same update.
- R5: `stage_act_i[i]` sets the flag of stage i and adds one to the count only if that flag was clear. On an already-active stage it has no effect.
- R6: `stage_deact_i[i]` clears the flag of stage i and subtracts one only if that flag was set. On an already-inactive stage it has no effect.
- R7: An activate and a deactivate for the same stage in the same cycle are both ignored.
- R8: A pulse, an advance and any number of stage requests in one cycle change the count by their net sum in a single update.
- R9: `active_o` is high exactly when the count is non-zero.
- R10: `flush_i` clears the count, every stage flag and the whole history at the next edge. No pulse recorded earlier can lower the count afterwards.
- R11: A wake at an edge with cycle index w, while the count is zero and `tick_pending_i` is low, adds w − 1 − L to `idle_total_o`. L is the cycle index of the most recent edge at which the count fell to zero; it is 0 if the count has not fallen to zero since reset.
- R12: A wake is ignored while the block is active or `tick_pending_i` is high.
- R13: The count always equals the set history slots plus the set stage flags plus the preload still in force. The preload is INIT_COUNT from reset until the first flush and 0 after it. The count never goes below zero or above LATENCY + NUM_STAGES + INIT_COUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the preload count |
| flush_i | input | 1 | Clears history, flags and count |
| advance_i | input | 1 | Moves the history one slot older |
| pulse_i | input | 1 | Communication was written this cycle |
| stage_act_i | input | NUM_STAGES | Per-stage activate requests |
| stage_deact_i | input | NUM_STAGES | Per-stage deactivate requests |
| wake_i | input | 1 | Wake event for idle-time accounting |
| tick_pending_i | input | 1 | A tick is already scheduled |
| active_o | output | 1 | Count is non-zero |
| count_o | output | CNT_W | Running activity count |
| idle_total_o | output | CYC_W | Accumulated idle cycles |

## Verification
A lost or doubled history bit or stage flag shows up on `count_o` at the edge after the faulty event. If the bad bit survives, the count then fails to return to zero LATENCY cycles later, or after the matching deactivate, so `active_o` stays stuck. A wrong last-running-cycle capture cannot be seen until the next accepted wake, where `idle_total_o` steps by the wrong amount.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Count must hold every history slot, every stage flag and the preload.
    function automatic int cnt_width(input int lat, input int stg, input int init);
        return $clog2(lat + stg + init + 2);
    endfunction

endpackage

// File: rtl/pit_history.sv
module pit_history #(
    parameter int LATENCY = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               advance_i,
    input  logic               pulse_i,
    output logic               inc_o,
    output logic               dec_o,
    output logic [LATENCY-1:0] hist_o
);

    logic [LATENCY-1:0] hist_q;
    logic [LATENCY-1:0] hist_next;
    logic [LATENCY-1:0] shifted;

    // Slot 0 is the newest entry, slot LATENCY-1 the oldest.
    generate
        if (LATENCY > 1) begin : g_multi
            assign shifted = {hist_q[LATENCY-2:0], pulse_i};
        end else begin : g_single
            assign shifted = pulse_i;
        end
    endgenerate

    always_comb begin
        hist_next = hist_q;
        inc_o     = 1'b0;
        dec_o     = 1'b0;
        if (advance_i) begin
            dec_o     = hist_q[LATENCY-1];
            inc_o     = pulse_i;
            hist_next = shifted;
        end else if (pulse_i && !hist_q[0]) begin
            inc_o        = 1'b1;
            hist_next[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_next;
        end
    end

    assign hist_o = hist_q;

    generate
        if (LATENCY > 1) begin : g_shift_chk
            // R2: every entry moves one slot older on an advance
            a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
                (advance_i && !flush_i) |=> hist_q[LATENCY-1:1] == $past(hist_q[LATENCY-2:0]));
        end
    endgenerate

    // R3: a pulse onto an occupied newest slot without advance leaves the line unchanged
    a_r3_dedupe: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !flush_i && pulse_i && hist_q[0]) |=> $stable(hist_q));

endmodule

// File: rtl/pit_stage_flags.sv
module pit_stage_flags #(
    parameter int NUM_STAGES = 4,
    parameter int SUM_W      = $clog2(NUM_STAGES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    input  logic [NUM_STAGES-1:0] act_i,
    input  logic [NUM_STAGES-1:0] deact_i,
    output logic [NUM_STAGES-1:0] flags_o,
    output logic [SUM_W-1:0]      n_set_o,
    output logic [SUM_W-1:0]      n_clr_o
);

    logic [NUM_STAGES-1:0] flag_q;
    logic [NUM_STAGES-1:0] set_req;
    logic [NUM_STAGES-1:0] clr_req;

    generate
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
            assign set_req[s] = act_i[s] && !deact_i[s] && !flag_q[s];
            assign clr_req[s] = deact_i[s] && !act_i[s] && flag_q[s];

            always_ff @(posedge clk) begin
                if (!rst_n || flush_i) begin
                    flag_q[s] <= 1'b0;
                end else if (set_req[s]) begin
                    flag_q[s] <= 1'b1;
                end else if (clr_req[s]) begin
                    flag_q[s] <= 1'b0;
                end
            end

            // R5: an activate on a set flag changes nothing
            a_r5_no_reactivate: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[s] && act_i[s] && !flush_i) |=> flag_q[s]);
            // R6: a deactivate on a clear flag changes nothing
            a_r6_no_redeactivate: assert property (@(posedge clk) disable iff (!rst_n)
                (!flag_q[s] && deact_i[s]) |=> !flag_q[s]);
        end
    endgenerate

    always_comb begin
        n_set_o = '0;
        n_clr_o = '0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            n_set_o = n_set_o + SUM_W'(set_req[i]);
            n_clr_o = n_clr_o + SUM_W'(clr_req[i]);
        end
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/pit_idle_acct.sv
module pit_idle_acct
    import pit_pkg::*;
#(
    parameter int   CYC_W     = 32,
    parameter int   CNT_W     = 4,
    parameter logic START_RUN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_q_i,
    input  logic [CNT_W-1:0] count_next_i,
    input  logic             wake_i,
    input  logic             tick_pending_i,
    output logic [CYC_W-1:0] idle_total_o
);

    run_state_e       state_q;
    run_state_e       state_next;
    logic             t_stop;
    logic             wake_ok;
    logic [CYC_W-1:0] cyc_q;
    logic [CYC_W-1:0] last_run_q;
    logic [CYC_W-1:0] idle_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= START_RUN ? ST_RUN : ST_IDLE;
        end else begin
            state_q <= state_next;
        end
    end

    // Transitions T_START and T_STOP
    always_comb begin
        state_next = state_q;
        t_stop     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (count_next_i != '0) state_next = ST_RUN;
            ST_RUN: begin
                if (count_next_i == '0) begin
                    state_next = ST_IDLE;
                    t_stop     = 1'b1;
                end
            end
            default: state_next = ST_IDLE;
        endcase
    end

    assign wake_ok = wake_i && (state_q == ST_IDLE) && !tick_pending_i;

    // Outputs and bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            last_run_q <= '0;
            idle_q     <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (t_stop) begin
                last_run_q <= cyc_q;
            end
            if (wake_ok) begin
                idle_q <= idle_q + (cyc_q - 1'b1 - last_run_q);
            end
        end
    end

    assign idle_total_o = idle_q;

    // R9: the idle state agrees with the count held by the top
    a_r9_state_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) == (count_q_i != '0));

    // R12: wake ignored while active or a tick is pending
    a_r12_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_i && (count_q_i != '0 || tick_pending_i)) |=> $stable(idle_q));

endmodule

// File: rtl/pit_consistency_chk.sv
module pit_consistency_chk #(
    parameter int NUM_STAGES = 4,
    parameter int LATENCY    = 5,
    parameter int INIT_COUNT = 0,
    parameter int CNT_W      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush_i,
    input logic [LATENCY-1:0]    hist_i,
    input logic [NUM_STAGES-1:0] flags_i,
    input logic [CNT_W-1:0]      count_i
);

    logic [CNT_W-1:0] bias_q;

    // The preload stays in force until the first flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bias_q <= CNT_W'(INIT_COUNT);
        end else if (flush_i) begin
            bias_q <= '0;
        end
    end

    // R13: the count equals a full recount of history and flags
    a_r13_recount: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count_i) == $countones(hist_i) + $countones(flags_i) + 32'(bias_q));

endmodule

// File: rtl/pipe_idle_tracker.sv
module pipe_idle_tracker
    import pit_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int LATENCY    = 5,
    parameter int INIT_COUNT = 0,
    parameter int CYC_W      = 32,
    parameter int CNT_W      = pit_pkg::cnt_width(LATENCY, NUM_STAGES, INIT_COUNT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    input  logic                  advance_i,
    input  logic                  pulse_i,
    input  logic [NUM_STAGES-1:0] stage_act_i,
    input  logic [NUM_STAGES-1:0] stage_deact_i,
    input  logic                  wake_i,
    input  logic                  tick_pending_i,
    output logic                  active_o,
    output logic [CNT_W-1:0]      count_o,
    output logic [CYC_W-1:0]      idle_total_o
);

    localparam int SUM_W   = $clog2(NUM_STAGES + 1);
    localparam int WIDE_W  = CNT_W + 2;
    localparam int CNT_MAX = LATENCY + NUM_STAGES + INIT_COUNT;

    logic                  h_inc;
    logic                  h_dec;
    logic [LATENCY-1:0]    hist;
    logic [NUM_STAGES-1:0] flags;
    logic [SUM_W-1:0]      n_set;
    logic [SUM_W-1:0]      n_clr;
    logic [CNT_W-1:0]      count_q;
    logic [CNT_W-1:0]      count_next;
    logic [WIDE_W-1:0]     add_w;
    logic [WIDE_W-1:0]     sub_w;

    pit_history #(.LATENCY(LATENCY)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .advance_i (advance_i),
        .pulse_i   (pulse_i),
        .inc_o     (h_inc),
        .dec_o     (h_dec),
        .hist_o    (hist)
    );

    pit_stage_flags #(.NUM_STAGES(NUM_STAGES), .SUM_W(SUM_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush_i),
        .act_i   (stage_act_i),
        .deact_i (stage_deact_i),
        .flags_o (flags),
        .n_set_o (n_set),
        .n_clr_o (n_clr)
    );

    // Net of every increment and decrement in one update.
    assign add_w = WIDE_W'(count_q) + WIDE_W'(h_inc) + WIDE_W'(n_set);
    assign sub_w = WIDE_W'(h_dec) + WIDE_W'(n_clr);

    always_comb begin
        if (flush_i) begin
            count_next = '0;
        end else begin
            count_next = CNT_W'(add_w - sub_w);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CNT_W'(INIT_COUNT);
        end else begin
            count_q <= count_next;
        end
    end

    pit_idle_acct #(
        .CYC_W     (CYC_W),
        .CNT_W     (CNT_W),
        .START_RUN (INIT_COUNT != 0)
    ) u_idle (
        .clk            (clk),
        .rst_n          (rst_n),
        .count_q_i      (count_q),
        .count_next_i   (count_next),
        .wake_i         (wake_i),
        .tick_pending_i (tick_pending_i),
        .idle_total_o   (idle_total_o)
    );

    pit_consistency_chk #(
        .NUM_STAGES (NUM_STAGES),
        .LATENCY    (LATENCY),
        .INIT_COUNT (INIT_COUNT),
        .CNT_W      (CNT_W)
    ) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush_i),
        .hist_i  (hist),
        .flags_i (flags),
        .count_i (count_q)
    );

    assign active_o = (count_q != '0);
    assign count_o  = count_q;

    // R13: decrements never exceed what is held
    a_r13_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i || (add_w >= sub_w));
    // R13: the count stays within its capacity
    a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i || ((add_w - sub_w) <= WIDE_W'(CNT_MAX)));

endmodule

// File: tb/pipe_idle_tracker_test.sv
module pipe_idle_tracker_test;

    localparam int S     = 4;
    localparam int L     = 5;
    localparam int CW    = 32;
    localparam int NW    = $clog2(L + S + 0 + 2);
    localparam int NW_P  = $clog2(L + S + 3 + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          adv = 1'b1;
    logic          pulse = 1'b0;
    logic [S-1:0]  act = '0;
    logic [S-1:0]  deact = '0;
    logic          wake = 1'b0;
    logic          pend = 1'b0;
    logic          active;
    logic [NW-1:0] count;
    logic [CW-1:0] idle;
    logic            p_active;
    logic [NW_P-1:0] p_count;
    logic [CW-1:0]   p_idle;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [CW-1:0] cyc_m;

    always #4 clk = ~clk;

    pipe_idle_tracker #(.NUM_STAGES(S), .LATENCY(L)) uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .advance_i(adv), .pulse_i(pulse),
        .stage_act_i(act), .stage_deact_i(deact), .wake_i(wake),
        .tick_pending_i(pend), .active_o(active), .count_o(count), .idle_total_o(idle)
    );

    pipe_idle_tracker #(.NUM_STAGES(S), .LATENCY(L), .INIT_COUNT(3)) uut_preload (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .advance_i(adv), .pulse_i(1'b0),
        .stage_act_i('0), .stage_deact_i('0), .wake_i(1'b0),
        .tick_pending_i(1'b0), .active_o(p_active), .count_o(p_count), .idle_total_o(p_idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cyc_m <= '0;
        else        cyc_m <= cyc_m + 1'b1;
    end

    task automatic check(input string tag, input longint actual, input longint expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 count", count, 0);
        check("R1 active", active, 0);
        check("R1 idle", idle, 0);
        check("R1 preload count", p_count, 3);
        check("R1 preload active", p_active, 1);
    endtask

    task automatic t_lone_pulse;
        adv = 1; pulse = 1; tick(1); pulse = 0;
        check("R2 after pulse", count, 1);
        check("R9 active high", active, 1);
        tick(4);
        check("R2 held L cycles", count, 1);
        tick(1);
        check("R4 oldest leaves", count, 0);
        check("R9 active low", active, 0);
    endtask

    task automatic t_dedupe;
        adv = 0; pulse = 1; tick(3); pulse = 0;
        check("R3 counted once", count, 1);
        adv = 1; tick(4);
        check("R3 still one", count, 1);
        tick(1);
        check("R3 drained", count, 0);
    endtask

    task automatic t_stage;
        act[1] = 1; tick(1);
        check("R5 activate", count, 1);
        tick(1); act[1] = 0;
        check("R5 reactivate ignored", count, 1);
        deact[2] = 1; tick(1); deact[2] = 0;
        check("R6 deact inactive ignored", count, 1);
        deact[1] = 1; tick(1);
        check("R6 deactivate", count, 0);
        tick(1); deact[1] = 0;
        check("R6 redeactivate ignored", count, 0);
    endtask

    task automatic t_same_stage;
        act[0] = 1; deact[0] = 1; tick(1); act[0] = 0; deact[0] = 0;
        check("R7 both on clear flag", count, 0);
        act[3] = 1; tick(1);
        deact[3] = 1; tick(1); act[3] = 0; deact[3] = 0;
        check("R7 both on set flag", count, 1);
        deact[3] = 1; tick(1); deact[3] = 0;
        check("R7 flag still set", count, 0);
    endtask

    task automatic t_net;
        act[1] = 1; tick(1); act[1] = 0;
        pulse = 1; tick(1); pulse = 0;
        check("R8 setup", count, 2);
        tick(4);
        check("R8 bit at oldest", count, 2);
        pulse = 1; act[0] = 1; act[2] = 1; deact[1] = 1;
        tick(1);
        pulse = 0; act = '0; deact = '0;
        check("R8 net update", count, 3);
        deact[0] = 1; deact[2] = 1; tick(1); deact = '0;
        check("R8 after clear flags", count, 1);
        tick(4);
        check("R8 drained", count, 0);
    endtask

    task automatic t_flush;
        act[0] = 1; act[2] = 1; pulse = 1; tick(1); act = '0; pulse = 0;
        check("R10 setup", count, 3);
        tick(3);
        check("R1 preload holds", p_count, 3);
        flush = 1; tick(1); flush = 0;
        check("R10 count cleared", count, 0);
        check("R10 preload cleared", p_count, 0);
        tick(6);
        check("R10 history cleared", count, 0);
        deact[0] = 1; tick(1); deact[0] = 0;
        check("R10 flag cleared", count, 0);
        act[0] = 1; tick(1); act[0] = 0;
        check("R10 reactivate after flush", count, 1);
        deact[0] = 1; tick(1); deact[0] = 0;
    endtask

    task automatic t_wake;
        logic [CW-1:0] d;
        logic [CW-1:0] w;
        logic [CW-1:0] exp_idle;
        act[0] = 1; tick(1); act[0] = 0;
        wake = 1; tick(1); wake = 0;
        check("R12 ignored when active", idle, 0);
        d = cyc_m; deact[0] = 1; tick(1); deact[0] = 0;
        tick(3);
        pend = 1; wake = 1; tick(1); pend = 0; wake = 0;
        check("R12 ignored when pending", idle, 0);
        w = cyc_m; wake = 1; tick(1); wake = 0;
        exp_idle = w - 1 - d;
        check("R11 first wake", idle, exp_idle);
        tick(2);
        w = cyc_m; wake = 1; tick(1); wake = 0;
        exp_idle = exp_idle + (w - 1 - d);
        check("R11 second wake", idle, exp_idle);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        t_lone_pulse();
        t_dedupe();
        t_stage();
        t_same_stage();
        t_net();
        t_flush();
        t_wake();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule